// File: doc/BRIEF.md
# Window Watchdog Timer

The block is a supervision timer for a processor subsystem. A 7-bit down-counter is clocked through a programmable divider of the bus clock. Software must reload it at intervals that are neither too long nor too short. The counter may be reloaded only after it has dropped to or below a programmable window value. A reload that comes too early, a reload with a value below the warning threshold, or a counter that runs past the threshold each raise a one-cycle system-reset request. The same request also returns the block to its reset state.

Software sees three registers through a simple write strobe and a combinational read port. The control register holds the enable bit and the counter. The configuration register holds the window, the divider select and the interrupt enable. The status register holds a warning flag. The flag is raised one counter step before the timeout, so software can get an interrupt and reload the counter in time.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the reads return: control (address 0) = 0x07F (enable bit 7 = 0, counter bits 6:0 = 0x7F); configuration (address 1) = 0x07F (window bits 6:0 = 0x7F, divider select bits 8:7 = 0, interrupt enable bit 9 = 0); status (address 2) = 0 (warning flag in bit 0). `rst_req` and `irq` are low.
- R2: The counter decrements once every BASE_DIV × 2^sel bus cycles, where sel is the 2-bit divider select. A control write loads the counter and restarts the divider, so the first decrement comes exactly one period after that write's clock edge.
- R3: While enabled, the counter stepping down from 0x40 raises `rst_req` at that same clock edge.
- R4: A control write whose counter value has bit 6 clear raises `rst_req` at its clock edge if the block was enabled before the write or the write itself sets the enable bit.
- R5: While enabled, a control write made when the counter is above the window raises `rst_req`. A write made when the counter is at or below the window is accepted. The window check applies only if the block was enabled before the write.
- R6: The enable bit is set by writing 1 to control bit 7. Writing 0 leaves it set. Only a reset or a reset request clears it.
- R7: The warning flag is set when the counter steps down to 0x40, whether or not the interrupt is enabled. Writing 0 to status bit 0 clears it. Writing 1 has no effect.
- R8: The interrupt enable is sticky in the same way as the enable bit. `irq` is high exactly while both the flag and the interrupt enable are set.
- R9: `rst_req` lasts one cycle. In that cycle every register already holds its R1 value.
- R10: While disabled, the counter accepts any written value and keeps decrementing, wrapping from 0x00 to 0x7F. `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write address: 0 control, 1 configuration, 2 status |
| wr_data | input | 10 | Write data, fields as in R1 |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 10 | Combinational read data of the addressed register |
| rst_req | output | 1 | One-cycle system-reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
Register writes take effect at the clock edge that captures them. `rst_req` is registered from the fault condition of that same edge, so after a write task returns at the following falling edge, both the new register value and any reset request are already visible. Because a control write restarts the divider, a decrement or a timeout falls exactly N × period edges after the write. The bench counts falling edges from that point and samples one edge before and exactly at the expected edge. The warning flag and `irq` follow the decrement edge with no extra delay, and they are checked in the same way.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2
  } wdg_reg_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int BASE_DIV = 4096,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int PW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [PW-1:0] div_q, div_d;
  logic [PW:0]   span, last;

  always_comb begin
    span = (PW+1)'(BASE_DIV) << sel;
    last = span - 1'b1;
    tick = ({1'b0, div_q} >= last);
    if (restart || tick) div_d = '0;
    else                 div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wdg_downcounter.sv
module wdg_downcounter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             evt_warn,
  output logic             evt_expire
);
  localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_upd;

  always_comb begin
    evt_warn   = tick && (cnt_q == WARN_VAL + 1'b1);
    evt_expire = tick && (cnt_q == WARN_VAL);
    cnt_upd    = clr || load || tick;
    if (clr)       cnt_d = '1;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '1;
    else if (cnt_upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs #(
  parameter int CNT_W = 7,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_win,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_ie,
  input  logic             stat_clr,
  input  logic             warn_evt,
  output logic             en_q,
  output logic             ie_q,
  output logic             flag_q,
  output logic [CNT_W-1:0] win_q,
  output logic [SEL_W-1:0] sel_q
);
  logic             en_d, ie_d, flag_d;
  logic [CNT_W-1:0] win_d;
  logic [SEL_W-1:0] sel_d;
  logic             cfg_upd;

  always_comb begin
    cfg_upd = clr || cfg_wr;
    en_d    = clr ? 1'b0 : (en_q || set_en);
    ie_d    = clr ? 1'b0 : (ie_q || (cfg_wr && cfg_ie));
    win_d   = clr ? '1 : cfg_win;
    sel_d   = clr ? '0 : cfg_sel;
    if (clr)           flag_d = 1'b0;
    else if (warn_evt) flag_d = 1'b1;
    else if (stat_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '1;
      sel_q <= '0;
    end else if (cfg_upd) begin
      win_q <= win_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int BASE_DIV = 4096,
  parameter int CNT_W    = 7,
  parameter int SEL_W    = 2,
  localparam int DW      = CNT_W + SEL_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rst_req,
  output logic          irq
);
  localparam int EN_BIT = CNT_W;
  localparam int IE_BIT = CNT_W + SEL_W;

  logic             rst_meta, rst_sync_n;
  logic             wr_ctrl, wr_cfg, wr_stat, stat_clr;
  logic             tick, evt_warn, evt_expire, warn_evt;
  logic             en_q, ie_q, flag_q;
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [SEL_W-1:0] sel_q;
  logic             low_write, early_write, expire, fault;
  logic             rst_req_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    wr_ctrl     = wr_en && (wr_addr == 2'(REG_CTRL));
    wr_cfg      = wr_en && (wr_addr == 2'(REG_CFG));
    wr_stat     = wr_en && (wr_addr == 2'(REG_STAT));
    stat_clr    = wr_stat && !wr_data[0];
    warn_evt    = evt_warn && !wr_ctrl;
    low_write   = wr_ctrl && !wr_data[CNT_W-1] && (en_q || wr_data[EN_BIT]);
    early_write = wr_ctrl && en_q && (cnt_q > win_q);
    expire      = en_q && evt_expire && !wr_ctrl;
    fault       = low_write || early_write || expire;
  end

  wdg_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .restart(wr_ctrl || fault),
    .sel(sel_q), .tick(tick)
  );

  wdg_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(fault), .tick(tick),
    .load(wr_ctrl), .load_val(wr_data[CNT_W-1:0]), .cnt_q(cnt_q),
    .evt_warn(evt_warn), .evt_expire(evt_expire)
  );

  wdg_cfg_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .clr(fault),
    .set_en(wr_ctrl && wr_data[EN_BIT]), .cfg_wr(wr_cfg),
    .cfg_win(wr_data[CNT_W-1:0]), .cfg_sel(wr_data[IE_BIT-1:CNT_W]),
    .cfg_ie(wr_data[IE_BIT]), .stat_clr(stat_clr), .warn_evt(warn_evt),
    .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q), .win_q(win_q), .sel_q(sel_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rst_req_q <= 1'b0;
    else             rst_req_q <= fault;
  end

  always_comb begin
    case (rd_addr)
      2'(REG_CTRL): rd_data = DW'({en_q, cnt_q});
      2'(REG_CFG):  rd_data = {ie_q, sel_q, win_q};
      2'(REG_STAT): rd_data = DW'(flag_q);
      default:      rd_data = '0;
    endcase
  end

  assign rst_req = rst_req_q;
  assign irq     = flag_q && ie_q;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctrl,
  input logic             en_bit,
  input logic             cnt_msb,
  input logic             stat_clr,
  input logic             en_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] win_q,
  input logic             rst_req
);
  AST_LOW_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !cnt_msb && (en_q || en_bit) |=> rst_req); // R4
  AST_EARLY_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && en_q && (cnt_q > win_q) |=> rst_req); // R5
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q || rst_req); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !stat_clr |=> flag_q || rst_req); // R7
  AST_IE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q |=> ie_q || rst_req); // R8
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !wr_ctrl |=> !rst_req); // R9
  AST_PULSE_STATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !en_q && !ie_q && !flag_q && (cnt_q == '1)); // R9
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !(wr_ctrl && en_bit) |=> !rst_req); // R10
endmodule

bind win_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_ctrl(wr_ctrl),
  .en_bit(wr_data[CNT_W]), .cnt_msb(wr_data[CNT_W-1]),
  .stat_clr(stat_clr), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
  .cnt_q(cnt_q), .win_q(win_q), .rst_req(rst_req)
);

// File: tb/sim_win_watchdog.sv
`timescale 1ns/1ps
module sim_win_watchdog;
  localparam int BD = 4;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [9:0] wr_data, rd_data;
  logic       rst_req, irq;
  int         checks = 0, failures = 0, rst_seen = 0;
  logic       done = 1'b0;

  win_watchdog #(.BASE_DIV(BD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .irq(irq)
  );

  always #5 clk = ~clk;

  // {window, first load, second load, reset expected}; loads carry enable
  localparam logic [21:0] VEC [7] = '{
    {7'h50, 7'h7F, 7'h7F, 1'b1},   // counter above window
    {7'h50, 7'h50, 7'h7F, 1'b0},   // counter equal to window
    {7'h50, 7'h4F, 7'h60, 1'b0},   // counter below window
    {7'h50, 7'h51, 7'h60, 1'b1},   // one above window
    {7'h7F, 7'h7F, 7'h3F, 1'b1},   // low value written
    {7'h7F, 7'h45, 7'h40, 1'b0},   // lowest legal value
    {7'h3F, 7'h40, 7'h70, 1'b1}    // window under threshold
  };

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [9:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_req) rst_seen++;
    end
  endtask

  task automatic hard_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] v;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; rst_n = 1'b0;
    @(negedge clk);
    hard_reset();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 10'h07F);
    rd(2'd1, v); chk("R1 cfg", v, 10'h07F);
    rd(2'd2, v); chk("R1 stat", v, 10'h000);
    chk("R1 rst_req", 10'(rst_req), 10'h0);
    chk("R1 irq", 10'(irq), 10'h0);

    // R5/R4 window table
    for (int i = 0; i < 7; i++) begin
      hard_reset();
      wr(2'd1, {1'b0, 2'd3, VEC[i][21:15]});
      wr(2'd0, {3'b001, VEC[i][14:8]});
      wr(2'd0, {3'b001, VEC[i][7:1]});
      chk($sformatf("R5 vec%0d rst_req", i), 10'(rst_req), 10'(VEC[i][0]));
      rd(2'd0, v);
      chk($sformatf("R5 vec%0d ctrl", i), v,
          VEC[i][0] ? 10'h07F : {3'b001, VEC[i][7:1]});
    end

    // R4 enable and low value in one write
    hard_reset();
    wr(2'd0, 10'h0B0);
    chk("R4 enable+low rst_req", 10'(rst_req), 10'h1);

    // R3 timeout exactly one period after loading 0x40, R9 pulse
    hard_reset();
    wr(2'd0, 10'h0C0);
    wait_n(BD - 1);
    chk("R3 no reset before period", 10'(rst_req), 10'h0);
    wait_n(1);
    chk("R3 reset at period", 10'(rst_req), 10'h1);
    rd(2'd0, v); chk("R9 ctrl cleared in pulse", v, 10'h07F);
    wait_n(1);
    chk("R9 pulse one cycle", 10'(rst_req), 10'h0);
    rd(2'd1, v); chk("R9 cfg cleared", v, 10'h07F);

    // R2 divider select 2 -> period 4*BD
    hard_reset();
    wr(2'd1, 10'h17F);
    wr(2'd0, 10'h050);
    wait_n(4*BD - 1);
    rd(2'd0, v); chk("R2 before decrement", v, 10'h050);
    wait_n(1);
    rd(2'd0, v); chk("R2 first decrement", v, 10'h04F);
    wait_n(4*BD);
    rd(2'd0, v); chk("R2 second decrement", v, 10'h04E);

    // R10 disabled behaviour
    hard_reset();
    rst_seen = 0;
    wr(2'd0, 10'h020);
    chk("R10 low write no reset", 10'(rst_req), 10'h0);
    rd(2'd0, v); chk("R10 low value loaded", v, 10'h020);
    wr(2'd0, 10'h000);
    wait_n(BD);
    rd(2'd0, v); chk("R10 wrap to 0x7F", v, 10'h07F);
    wr(2'd0, 10'h040);
    wait_n(BD + 2);
    rd(2'd0, v); chk("R10 passes 0x40", v, 10'h03F);
    chk("R10 no reset seen", 10'(rst_seen), 10'h0);

    // R6 enable sticky
    hard_reset();
    wr(2'd0, 10'h0FF);
    wr(2'd0, 10'h060);
    chk("R6 write inside window", 10'(rst_req), 10'h0);
    rd(2'd0, v); chk("R6 enable kept", v, 10'h0E0);

    // R7/R8 flag and interrupt, divider select 1 -> period 2*BD
    hard_reset();
    wr(2'd1, 10'h0FF);
    wr(2'd0, 10'h0C1);
    wait_n(2*BD - 1);
    rd(2'd2, v); chk("R7 flag not yet", v, 10'h000);
    wait_n(1);
    rd(2'd2, v); chk("R7 flag set without ie", v, 10'h001);
    chk("R8 irq masked", 10'(irq), 10'h0);
    wr(2'd1, 10'h2FF);
    chk("R8 irq raised", 10'(irq), 10'h1);
    wr(2'd2, 10'h001);
    rd(2'd2, v); chk("R7 write 1 no effect", v, 10'h001);
    wr(2'd2, 10'h000);
    rd(2'd2, v); chk("R7 write 0 clears", v, 10'h000);
    chk("R8 irq follows flag", 10'(irq), 10'h0);
    wr(2'd1, 10'h0FF);
    rd(2'd1, v); chk("R8 ie sticky", v, 10'h2FF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule